// File: doc/BRIEF.md
# Single-Wire Debug Host Bit Transceiver

This block is the host end of a bidirectional single-wire debug link. It opens every bit slot on the shared line and counts time in periods of its own clock. That clock is taken to run at the target's debug clock rate. The block sequences one bit at a time. Byte assembly, the command layer and discovery of the target's clock rate belong to logic above it.

A slot begins with a one-cycle `start_i` strobe while the block is idle. The `wr_i` input picks the slot type: 1 is a write and 0 is a read. `tx_bit_i` gives the bit to write.

- **Read slot.** The host pulls the line low only briefly. This marks the slot start for the target. The host then lets go well before the target's own edge-speedup pulse, so the two never fight. It then captures the level the target leaves on the line.
- **Write slot.** The host shapes the whole waveform itself. The length of the low phase encodes the bit. The host then drives the line high for one cycle so the rising edge is sharp.

The line input passes through a synchronizer before sampling. The sample point allows for that delay. When a slot ends, `done_o` pulses for one cycle and `rx_bit_o` holds the captured level.

Top module: `dbg_bit_host`

## Requirements
- R1: After reset, `pin_oe_o`, `done_o` and `busy_o` are all 0, and the line is released.
- R2: A `start_i` sampled high while idle opens a slot. In slot cycle 0 (the cycle after that edge), `busy_o`=1, `pin_oe_o`=1 and `pin_o`=0, so the line is pulled low.
- R3: In a read slot (`wr_i`=0) the host drives the line low in cycles 0 and 1 only. It releases the line (`pin_oe_o`=0) in cycles 2 to 15 and never drives it high.
- R4: In a write slot with `tx_bit_i`=0 the line is driven low in cycles 0 to 12 and driven high (`pin_oe_o`=1, `pin_o`=1) in cycle 13. It is released in cycles 14 and 15.
- R5: In a write slot with `tx_bit_i`=1 the line is driven low in cycles 0 to 3 and driven high in cycle 4. It is released in cycles 5 to 15.
- R6: At `done_o`, `rx_bit_o` equals the level `pin_i` had during slot cycle 10. Any other cycle of the slot has no effect on it. This holds for both slot types.
- R7: `done_o` is 1 only in cycle 16 of each slot. `busy_o` is 0 in that same cycle, and the line is released.
- R8: A `start_i` raised while `busy_o`=1 is ignored. The slot waveform is unchanged and no further slot follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock at the target debug clock rate |
| rst_i | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Opens a slot when idle |
| wr_i | input | 1 | Slot type: 1 write, 0 read |
| tx_bit_i | input | 1 | Bit sent in a write slot |
| pin_i | input | 1 | Line level as seen at the pad |
| pin_o | output | 1 | Level driven onto the line |
| pin_oe_o | output | 1 | Drive enable for the line |
| busy_o | output | 1 | A slot is in progress |
| done_o | output | 1 | One-cycle end-of-slot strobe |
| rx_bit_o | output | 1 | Line level captured in the slot |

## Verification
The assertions take for granted that `start_i`, `wr_i` and `tx_bit_i` are synchronous to the clock. `wr_i` and `tx_bit_i` only matter in the cycle where a start is accepted. The stimulus drives every input on the falling clock edge. It picks random slot types, bits and line levels, and it toggles `start_i` at random only while a slot is running, to exercise R8. It drops `start_i` before the end-of-slot cycle so that no unintended slot opens. The modelled target drives the cycle-10 level apart from the level in every other cycle, so a shifted sample point shows up in `rx_bit_o`.

// File: rtl/dbg_bit_pkg.sv
package dbg_bit_pkg;
  typedef enum logic [1:0] {
    DRV_REL  = 2'd0,
    DRV_LOW  = 2'd1,
    DRV_HIGH = 2'd2
  } drv_e;
endpackage

// File: rtl/dbg_lvl_sync.sv
module dbg_lvl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) chain_q <= '1;
    else       chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/dbg_slot_timer.sv
module dbg_slot_timer #(
  parameter int SLOT_CYC = 16,
  localparam int CW = $clog2(SLOT_CYC)
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          start_i,
  output logic          accept_o,
  output logic          busy_o,
  output logic          last_o,
  output logic [CW-1:0] cnt_o,
  output logic          done_o
);
  localparam logic [CW-1:0] LAST = CW'(SLOT_CYC - 1);

  assign accept_o = start_i && !busy_o;
  assign last_o   = busy_o && (cnt_o == LAST);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      busy_o <= 1'b0;
      cnt_o  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (accept_o) begin
        busy_o <= 1'b1;
        cnt_o  <= '0;
      end else if (last_o) begin
        busy_o <= 1'b0;
        done_o <= 1'b1;
      end else if (busy_o) begin
        cnt_o  <= cnt_o + CW'(1);
      end
    end
  end
endmodule

// File: rtl/dbg_drive_shaper.sv
module dbg_drive_shaper
  import dbg_bit_pkg::*;
#(
  parameter int SLOT_CYC = 16,
  parameter int RD_LOW   = 2,
  parameter int W0_LOW   = 13,
  parameter int W1_LOW   = 4,
  localparam int CW = $clog2(SLOT_CYC)
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          accept_i,
  input  logic          busy_i,
  input  logic          last_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          wr_i,
  input  logic          tx_bit_i,
  output logic          wr_q_o,
  output logic          bit_q_o,
  output logic          pin_o,
  output logic          pin_oe_o
);
  function automatic drv_e drive_at(input logic wr, input logic b, input logic [CW-1:0] k);
    logic [CW-1:0] len;
    if (!wr) return (k < CW'(RD_LOW)) ? DRV_LOW : DRV_REL;
    len = b ? CW'(W1_LOW) : CW'(W0_LOW);
    if (k < len)  return DRV_LOW;
    if (k == len) return DRV_HIGH;
    return DRV_REL;
  endfunction

  drv_e nxt;

  always_comb begin
    nxt = DRV_REL;
    if (accept_i)                nxt = drive_at(wr_i, tx_bit_i, '0);
    else if (busy_i && !last_i)  nxt = drive_at(wr_q_o, bit_q_o, cnt_i + CW'(1));
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      wr_q_o   <= 1'b0;
      bit_q_o  <= 1'b0;
      pin_o    <= 1'b0;
      pin_oe_o <= 1'b0;
    end else begin
      if (accept_i) begin
        wr_q_o  <= wr_i;
        bit_q_o <= tx_bit_i;
      end
      pin_oe_o <= (nxt != DRV_REL);
      pin_o    <= (nxt == DRV_HIGH);
    end
  end
endmodule

// File: rtl/dbg_bit_host.sv
module dbg_bit_host #(
  parameter int SLOT_CYC    = 16,
  parameter int RD_LOW      = 2,
  parameter int W0_LOW      = 13,
  parameter int W1_LOW      = 4,
  parameter int SAMPLE_AT   = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic start_i,
  input  logic wr_i,
  input  logic tx_bit_i,
  input  logic pin_i,
  output logic pin_o,
  output logic pin_oe_o,
  output logic busy_o,
  output logic done_o,
  output logic rx_bit_o
);
  localparam int CW = $clog2(SLOT_CYC);
  localparam logic [CW-1:0] CAPTURE_CNT = CW'(SAMPLE_AT + SYNC_STAGES);

  logic          accept;
  logic          last;
  logic [CW-1:0] cnt;
  logic          wr_q;
  logic          bit_q;
  logic          pin_sync;

  dbg_slot_timer #(.SLOT_CYC(SLOT_CYC)) timer_i (
    .clk_i(clk_i), .rst_i(rst_i), .start_i(start_i),
    .accept_o(accept), .busy_o(busy_o), .last_o(last),
    .cnt_o(cnt), .done_o(done_o)
  );

  dbg_drive_shaper #(
    .SLOT_CYC(SLOT_CYC), .RD_LOW(RD_LOW), .W0_LOW(W0_LOW), .W1_LOW(W1_LOW)
  ) shaper_i (
    .clk_i(clk_i), .rst_i(rst_i), .accept_i(accept), .busy_i(busy_o),
    .last_i(last), .cnt_i(cnt), .wr_i(wr_i), .tx_bit_i(tx_bit_i),
    .wr_q_o(wr_q), .bit_q_o(bit_q), .pin_o(pin_o), .pin_oe_o(pin_oe_o)
  );

  dbg_lvl_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk_i(clk_i), .rst_i(rst_i), .d_i(pin_i), .q_o(pin_sync)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i)                            rx_bit_o <= 1'b0;
    else if (busy_o && cnt == CAPTURE_CNT) rx_bit_o <= pin_sync;
  end
endmodule

// File: rtl/dbg_bit_host_chk.sv
module dbg_bit_host_chk #(
  parameter int SLOT_CYC = 16,
  parameter int RD_LOW   = 2,
  parameter int W1_LOW   = 4,
  localparam int CW = $clog2(SLOT_CYC)
) (
  input logic          clk_i,
  input logic          rst_i,
  input logic          busy,
  input logic [CW-1:0] cnt,
  input logic          wr_q,
  input logic          bit_q,
  input logic          pin_o,
  input logic          pin_oe_o,
  input logic          done_o
);
  // R2: a new slot always opens with a low drive
  p_slot_opens_low_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(busy) |-> (pin_oe_o && !pin_o));

  // R3: read slot releases after the short low phase
  p_read_release_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    (busy && !wr_q && cnt >= CW'(RD_LOW)) |-> !pin_oe_o);

  // R3: read slot never drives high
  p_read_no_high_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    (busy && !wr_q) |-> !(pin_oe_o && pin_o));

  // R5: write-one speedup cycle
  p_w1_speedup_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    (busy && wr_q && bit_q && cnt == CW'(W1_LOW)) |-> (pin_oe_o && pin_o));

  // R7: done is a single-cycle pulse with the line released
  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    done_o |=> !done_o);
  p_done_idle_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    done_o |-> (!busy && !pin_oe_o));

  // R8: the slot count advances by one while busy, whatever start does
  p_count_steady_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    (busy && cnt != CW'(SLOT_CYC - 1)) |=> (busy && cnt == $past(cnt) + CW'(1)));
endmodule

bind dbg_bit_host dbg_bit_host_chk #(
  .SLOT_CYC(SLOT_CYC), .RD_LOW(RD_LOW), .W1_LOW(W1_LOW)
) chk_i (
  .clk_i(clk_i), .rst_i(rst_i), .busy(busy_o), .cnt(cnt), .wr_q(wr_q),
  .bit_q(bit_q), .pin_o(pin_o), .pin_oe_o(pin_oe_o), .done_o(done_o)
);

// File: tb/dbg_bit_host_tb.sv
module dbg_bit_host_tb_top;
  logic clk = 1'b0;
  logic rst, start, wr, txb, pin_in;
  logic pin_out, pin_oe, busy, done, rxb;
  int checks = 0;
  int fails  = 0;
  logic finished = 1'b0;

  always #2.5 clk = ~clk;

  dbg_bit_host dut_i (
    .clk_i(clk), .rst_i(rst), .start_i(start), .wr_i(wr), .tx_bit_i(txb),
    .pin_i(pin_in), .pin_o(pin_out), .pin_oe_o(pin_oe), .busy_o(busy),
    .done_o(done), .rx_bit_o(rxb)
  );

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp, input int cyc);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cycle %0d: actual %b expected %b", req, cyc, act, exp);
    end
  endtask

  // expected {oe, out} for slot cycle k from the requirements
  function automatic logic [1:0] exp_drive(input logic w, input logic b, input int k);
    int len;
    if (!w) return (k < 2) ? 2'b10 : 2'b00;            // R3
    len = b ? 4 : 13;                                   // R4 / R5
    if (k < len)  return 2'b10;
    if (k == len) return 2'b11;
    return 2'b00;
  endfunction

  task automatic run_slot(input logic w, input logic b, input logic lvl10,
                          input logic lvl_other, input logic noisy);
    logic [1:0] d;
    logic exp_rx;
    string rq;
    exp_rx = 1'b1;
    rq = !w ? "R3" : (b ? "R5" : "R4");
    start = 1'b1; wr = w; txb = b; pin_in = 1'b1;
    @(negedge clk);
    start = 1'b0; wr = $urandom_range(0, 1); txb = $urandom_range(0, 1);
    for (int k = 0; k < 16; k++) begin
      d = exp_drive(w, b, k);
      if (k == 0) chk("R2", {2'b0, busy, pin_oe}, {2'b0, 1'b1, 1'b1}, k);
      chk(rq, {2'b0, pin_oe, pin_out}, {2'b0, d}, k);
      if (d == 2'b10)      pin_in = 1'b0;
      else if (d == 2'b11) pin_in = 1'b1;
      else                 pin_in = (k == 10) ? lvl10 : lvl_other;
      if (k == 10) exp_rx = pin_in;
      start = (noisy && k < 14) ? 1'($urandom_range(0, 1)) : 1'b0;   // R8
      @(negedge clk);
    end
    pin_in = 1'b1;
    chk("R7", {1'b0, done, busy, pin_oe}, {1'b0, 1'b1, 1'b0, 1'b0}, 16);
    chk("R6", {3'b0, rxb}, {3'b0, exp_rx}, 16);
    @(negedge clk);
    chk("R8", {2'b0, done, busy}, 4'b0, 17);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    rst = 1'b1; start = 1'b0; wr = 1'b0; txb = 1'b0; pin_in = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", {1'b0, pin_oe, done, busy}, 4'b0, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", {1'b0, pin_oe, done, busy}, 4'b0, 0);
    // directed corners: sample point isolation (R6)
    run_slot(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    run_slot(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    run_slot(1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
    run_slot(1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    run_slot(1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
    run_slot(1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
    for (int n = 0; n < 60; n++)
      run_slot(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
               1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
               1'($urandom_range(0, 1)));
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule